// File: doc/BRIEF.md
# Down-Counting Compare Timer

A 32-bit periodic timer that sits on a simple word-wide register bus. A down counter steps once for every programmed number of ticks from one of three tick-enable inputs. When it reaches zero it either reloads from a programmable load value or wraps to all ones. Software places a compare value. The step on which the counter lands on that value sets a sticky status flag. The same step can raise a level interrupt and drive an output pin in a programmable way.

Typical use: software writes the load and compare registers, picks a tick source and a divide ratio, then sets the run bit. It services the interrupt by writing one to the status flag. With all ones in the load register and reload mode off, the block acts as a free-running down counter whose value software reads as a time base.

Top module: `cmp_timer`

## Requirements
- R1: Registers are decoded from byte address bits 4:2: control at 0x00, status at 0x04, load at 0x08, compare at 0x0C, counter at 0x10. Control keeps bits 25:0 and reads zero above them. Status bit 0 is the flag. Writes to the counter address are ignored. Unmapped addresses read zero.
- R2: Control bits 25:24 pick the tick source: 0 none (no counting), 1 `tick_periph`, 2 `tick_ref_hi`, 3 `tick_ref_lo`. Ticks on inputs that are not selected have no effect.
- R3: With run (control bit 0) set, the counter takes one step every D+1 ticks of the selected source, where D is control bits 15:4.
- R4: A step from a non-zero value decrements the counter. With reload mode (control bit 3) clear, a step from zero gives 0xFFFFFFFF.
- R5: With reload mode set, a step from zero loads the load register value.
- R6: A compare match sets status bit 0 in the same clock as the step. Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly while the status flag and the interrupt enable (control bit 2) are both set. Clearing the enable drops `irq` and leaves the flag set.
- R8: Control bits 23:22 set the pin action on a match: 0 holds `out_pin` low, 1 toggles it, 2 clears it, 3 sets it.
- R9: A control write that sets run while run was clear, with restart mode (control bit 1) in the written value, copies the load value into the counter and restarts the divider. Without restart mode the counter resumes from its held value. While run is clear the counter does not move.
- R10: A load write copies the data into the counter only while control bit 17 is set. Otherwise the counter is untouched.
- R11: Writing control bit 16 returns every register, the counter, the flag and the pin to their reset values on the following clock, and the bit reads back clear afterwards.
- R12: A match counts only on the step that brings the counter to the compare value. A counter that stays on the compare value does not set the flag again after it is cleared.
- R13: After reset: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF, `irq` and `out_pin` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| tick_periph | input | 1 | Tick enable, source 1 |
| tick_ref_hi | input | 1 | Tick enable, source 2 |
| tick_ref_lo | input | 1 | Tick enable, source 3 |
| irq | output | 1 | Level interrupt |
| out_pin | output | 1 | Compare-driven output pin |

## Verification
The bench sets the counter a few counts from zero and steps it through the wrap. A design that reloads when it should wrap, or wraps when it should reload, shows the wrong counter value after the step from zero. It holds the counter on the compare value after clearing the flag; a level-triggered match would set the flag again at once. It walks the pin through all four actions, pulses tick inputs that are not selected, and checks that a load write without the overwrite bit leaves the counter alone. It also checks that a restart enable takes the load value while a plain enable resumes. Random runs over several divide ratios and tick sources compare the counter against the tick count divided by the ratio, which exposes off-by-one dividers.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;

    // control word, bit 0 at the bottom
    typedef struct packed {
        logic [1:0]  clk_sel;   // 25:24
        logic [1:0]  pin_mode;  // 23:22
        logic [3:0]  keep;      // 21:18 stored only
        logic        ovw_en;    // 17
        logic        soft_rst;  // 16
        logic [11:0] div;       // 15:4
        logic        reload;    // 3
        logic        irq_en;    // 2
        logic        restart;   // 1
        logic        run;       // 0
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned DIV_W  = 12;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PER  = 2'd1,
        SRC_HI   = 2'd2,
        SRC_LO   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PIN_OFF = 2'd0,
        PIN_TGL = 2'd1,
        PIN_CLR = 2'd2,
        PIN_SET = 2'd3
    } pin_e;

    typedef enum logic [2:0] {
        IDX_CTRL = 3'd0,
        IDX_STAT = 3'd1,
        IDX_LOAD = 3'd2,
        IDX_CMP  = 3'd3,
        IDX_CNT  = 3'd4
    } idx_e;

endpackage

// File: rtl/cmpt_regs.sv
module cmpt_regs
    import cmpt_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          match_i,
    input  logic [DW-1:0] cnt_i,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] cmp_o,
    output logic          flag_o,
    output logic          start_o,
    output logic          ovw_o,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned IW = AW - 2;

    typedef struct packed {
        ctrl_t         ctrl;
        logic          flag;
        logic [DW-1:0] load;
        logic [DW-1:0] cmp;
    } regs_t;

    localparam regs_t RST_VAL = '{ctrl: '0, flag: 1'b0, load: '1, cmp: '0};

    regs_t         q, d;
    logic [IW-1:0] idx;
    logic          wr;
    ctrl_t         wctrl;

    assign idx   = bus_addr[AW-1:2];
    assign wr    = bus_sel && bus_wr;
    assign wctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    always_comb begin
        d       = q;
        start_o = 1'b0;
        ovw_o   = 1'b0;
        if (q.ctrl.soft_rst) begin
            d = RST_VAL;
        end else begin
            if (wr) begin
                case (idx)
                    IW'(IDX_CTRL): begin
                        d.ctrl  = wctrl;
                        start_o = wctrl.run && wctrl.restart && !q.ctrl.run;
                    end
                    IW'(IDX_LOAD): begin
                        d.load = bus_wdata;
                        ovw_o  = q.ctrl.ovw_en;
                    end
                    IW'(IDX_CMP):  d.cmp = bus_wdata;
                    default: ;
                endcase
            end
            if (match_i) begin
                d.flag = 1'b1;
            end else if (wr && idx == IW'(IDX_STAT) && bus_wdata[0]) begin
                d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        case (idx)
            IW'(IDX_CTRL): rdata_o[CTRL_W-1:0] = q.ctrl;
            IW'(IDX_STAT): rdata_o[0] = q.flag;
            IW'(IDX_LOAD): rdata_o = q.load;
            IW'(IDX_CMP):  rdata_o = q.cmp;
            IW'(IDX_CNT):  rdata_o = cnt_i;
            default:       rdata_o = '0;
        endcase
    end

    assign ctrl_o = q.ctrl;
    assign load_o = q.load;
    assign cmp_o  = q.cmp;
    assign flag_o = q.flag;

    logic unused_bits;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:CTRL_W]};

    // R6: a one written to the flag clears it when no match competes
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IW'(IDX_STAT) && bus_wdata[0] && !match_i && !q.ctrl.soft_rst)
        |=> !q.flag);

    // R6: a match always leaves the flag set
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && !q.ctrl.soft_rst) |=> q.flag);

    // R11: soft reset returns the register file to its reset image
    a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        q.ctrl.soft_rst |=> (q.ctrl == '0 && !q.flag && q.load == '1 && q.cmp == '0));

endmodule

// File: rtl/cmpt_presc.sv
module cmpt_presc
    import cmpt_pkg::*;
#(
    parameter int unsigned PW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [1:0]    sel_i,
    input  logic [PW-1:0] div_i,
    input  logic          tick_per_i,
    input  logic          tick_hi_i,
    input  logic          tick_lo_i,
    output logic          step_o
);

    typedef struct packed {
        logic [PW-1:0] pcnt;
    } presc_t;

    presc_t     q, d;
    logic [3:0] src_vec;
    logic       src;
    logic       hit;

    assign src_vec = {tick_lo_i, tick_hi_i, tick_per_i, 1'b0};
    assign src     = src_vec[sel_i];
    assign hit     = (q.pcnt >= div_i);

    always_comb begin
        d      = q;
        step_o = 1'b0;
        if (clear_i) begin
            d.pcnt = '0;
        end else if (run_i && src) begin
            if (hit) begin
                d.pcnt = '0;
                step_o = 1'b1;
            end else begin
                d.pcnt = q.pcnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: no steps without a tick source
    a_r2_src_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == SRC_NONE) |-> !step_o);

    // R3: the divider restarts after every step
    a_r3_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (q.pcnt == '0));

endmodule

// File: rtl/cmpt_core.sv
module cmpt_core
    import cmpt_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst_i,
    input  logic          start_i,
    input  logic          ovw_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          step_i,
    input  logic          reload_i,
    input  logic [DW-1:0] load_i,
    input  logic [DW-1:0] cmp_i,
    input  logic [1:0]    pin_mode_i,
    output logic [DW-1:0] cnt_o,
    output logic          match_o,
    output logic          pin_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          pin;
    } core_t;

    core_t         q, d;
    logic [DW-1:0] nxt;

    always_comb begin
        if (q.cnt == '0) nxt = reload_i ? load_i : '1;
        else             nxt = q.cnt - DW'(1);
    end

    always_comb begin
        d       = q;
        match_o = 1'b0;
        if (srst_i) begin
            d = '{cnt: '1, pin: 1'b0};
        end else begin
            if (start_i)      d.cnt = load_i;
            else if (ovw_i)   d.cnt = wdata_i;
            else if (step_i) begin
                d.cnt   = nxt;
                match_o = (nxt == cmp_i);
            end
            if (pin_mode_i == PIN_OFF) begin
                d.pin = 1'b0;
            end else if (match_o) begin
                case (pin_mode_i)
                    PIN_TGL: d.pin = !q.pin;
                    PIN_CLR: d.pin = 1'b0;
                    PIN_SET: d.pin = 1'b1;
                    default: d.pin = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '1, pin: 1'b0};
        else        q <= d;
    end

    assign cnt_o = q.cnt;
    assign pin_o = q.pin && (pin_mode_i != PIN_OFF);

    // R4: plain step from a non-zero value decrements by one
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !srst_i && !start_i && !ovw_i && q.cnt != '0)
        |=> (q.cnt == $past(q.cnt) - DW'(1)));

    // R5: step from zero in reload mode takes the load value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !srst_i && !start_i && !ovw_i && q.cnt == '0 && reload_i)
        |=> (q.cnt == $past(load_i)));

    // R8: set action drives the pin high after a match
    a_r8_pin_set: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && pin_mode_i == PIN_SET && !srst_i) |=> q.pin);

    // R12: no match without a step
    a_r12_step_only: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(q.cnt) |-> !$past(match_o));

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmpt_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_periph,
    input  logic          tick_ref_hi,
    input  logic          tick_ref_lo,
    output logic          irq,
    output logic          out_pin
);

    ctrl_t         ctrl;
    logic [DW-1:0] load_v, cmp_v, cnt_v;
    logic          flag, start, ovw, match, step;

    cmpt_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .match_i   (match),
        .cnt_i     (cnt_v),
        .ctrl_o    (ctrl),
        .load_o    (load_v),
        .cmp_o     (cmp_v),
        .flag_o    (flag),
        .start_o   (start),
        .ovw_o     (ovw),
        .rdata_o   (bus_rdata)
    );

    cmpt_presc #(.PW(DIV_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start || ctrl.soft_rst),
        .run_i      (ctrl.run),
        .sel_i      (ctrl.clk_sel),
        .div_i      (ctrl.div),
        .tick_per_i (tick_periph),
        .tick_hi_i  (tick_ref_hi),
        .tick_lo_i  (tick_ref_lo),
        .step_o     (step)
    );

    cmpt_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (ctrl.soft_rst),
        .start_i    (start),
        .ovw_i      (ovw),
        .wdata_i    (bus_wdata),
        .step_i     (step),
        .reload_i   (ctrl.reload),
        .load_i     (load_v),
        .cmp_i      (cmp_v),
        .pin_mode_i (ctrl.pin_mode),
        .cnt_o      (cnt_v),
        .match_o    (match),
        .pin_o      (out_pin)
    );

    assign irq = flag && ctrl.irq_en;

    logic unused_ctrl;
    assign unused_ctrl = ^{ctrl.keep, ctrl.ovw_en, ctrl.restart};

    // R7: the interrupt never outlives the enable bit
    a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |-> !irq);

endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;

    localparam logic [31:0] C_RUN  = 32'h1;
    localparam logic [31:0] C_RST  = 32'h2;
    localparam logic [31:0] C_IRQ  = 32'h4;
    localparam logic [31:0] C_RLD  = 32'h8;
    localparam logic [31:0] C_SRST = 32'h1_0000;
    localparam logic [31:0] C_OVW  = 32'h2_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        t_per = 1'b0, t_hi = 1'b0, t_lo = 1'b0;
    logic        irq, out_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    cmp_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_periph(t_per), .tick_ref_hi(t_hi), .tick_ref_lo(t_lo),
        .irq(irq), .out_pin(out_pin)
    );

    function automatic logic [31:0] src(input int s);
        return 32'(s) << 24;
    endfunction
    function automatic logic [31:0] pdiv(input int p);
        return 32'(p) << 4;
    endfunction
    function automatic logic [31:0] pmode(input int m);
        return 32'(m) << 22;
    endfunction
    function automatic logic [31:0] exp_count(input logic [31:0] s, input int ticks, input int p);
        return s - 32'(ticks / (p + 1));
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic chk_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // bit0 periph, bit1 ref_hi, bit2 ref_lo
    task automatic pulse(input logic [2:0] which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {t_lo, t_hi, t_per} = which;
        end
        @(negedge clk);
        {t_lo, t_hi, t_per} = 3'b000;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk_reg("R13 ctrl", 5'h00, 32'h0);
        chk_reg("R13 stat", 5'h04, 32'h0);
        chk_reg("R13 load", 5'h08, 32'hFFFF_FFFF);
        chk_reg("R13 cmp",  5'h0C, 32'h0);
        chk_reg("R13 cnt",  5'h10, 32'hFFFF_FFFF);
        check("R13 irq", {31'b0, irq}, 0);
        check("R13 pin", {31'b0, out_pin}, 0);

        // R1 register map
        wr(5'h10, 32'h0);
        chk_reg("R1 cnt read-only", 5'h10, 32'hFFFF_FFFF);
        wr(5'h08, 32'h1234_5678);
        chk_reg("R1 load", 5'h08, 32'h1234_5678);
        wr(5'h0C, 32'hA5A5_A5A5);
        chk_reg("R1 cmp", 5'h0C, 32'hA5A5_A5A5);
        wr(5'h00, 32'hFFEE_FFFE);
        chk_reg("R1 ctrl", 5'h00, 32'h03EE_FFFE);
        chk_reg("R1 unmapped", 5'h18, 32'h0);
        chk_reg("R10 load w/o ovw", 5'h10, 32'hFFFF_FFFF);
        wr(5'h00, 32'h0);

        // R3 / R2 divider and source selection
        wr(5'h00, C_OVW);
        wr(5'h08, 32'd100);
        chk_reg("R10 overwrite", 5'h10, 32'd100);
        wr(5'h00, C_RUN | C_OVW | src(1) | pdiv(2));
        pulse(3'b001, 9);
        chk_reg("R3 div3", 5'h10, 32'd97);
        pulse(3'b110, 4);
        chk_reg("R2 unselected", 5'h10, 32'd97);
        wr(5'h00, C_RUN | C_OVW | src(0));
        pulse(3'b111, 5);
        chk_reg("R2 off", 5'h10, 32'd97);
        wr(5'h00, C_RUN | C_OVW | src(2));
        pulse(3'b010, 5);
        chk_reg("R2 ref_hi", 5'h10, 32'd92);
        wr(5'h00, C_RUN | C_OVW | src(3));
        pulse(3'b100, 4);
        chk_reg("R2 ref_lo", 5'h10, 32'd88);

        // R4 wrap
        wr(5'h0C, 32'h50);
        wr(5'h08, 32'd2);
        wr(5'h00, C_RUN | C_OVW | src(1));
        pulse(3'b001, 3);
        chk_reg("R4 wrap", 5'h10, 32'hFFFF_FFFF);
        pulse(3'b001, 1);
        chk_reg("R4 after wrap", 5'h10, 32'hFFFF_FFFE);

        // R5 reload
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1));
        wr(5'h08, 32'd3);
        pulse(3'b001, 4);
        chk_reg("R5 reload", 5'h10, 32'd3);
        pulse(3'b001, 1);
        chk_reg("R5 after reload", 5'h10, 32'd2);

        // R6 / R7 / R12 flag and interrupt
        wr(5'h0C, 32'd1);
        wr(5'h00, C_RUN | C_OVW | C_RLD | C_IRQ | src(1));
        wr(5'h08, 32'd3);
        pulse(3'b001, 2);
        chk_reg("R6 flag set", 5'h04, 32'h1);
        check("R7 irq high", {31'b0, irq}, 1);
        wr(5'h04, 32'h1);
        chk_reg("R6 flag clear", 5'h04, 32'h0);
        check("R7 irq low", {31'b0, irq}, 0);
        repeat (5) @(negedge clk);
        chk_reg("R12 stalled cnt", 5'h10, 32'd1);
        chk_reg("R12 no refire", 5'h04, 32'h0);
        pulse(3'b001, 4);
        chk_reg("R12 refire on entry", 5'h04, 32'h1);
        wr(5'h04, 32'h0);
        chk_reg("R6 write zero", 5'h04, 32'h1);
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1));
        check("R7 enable off", {31'b0, irq}, 0);
        chk_reg("R7 flag kept", 5'h04, 32'h1);
        wr(5'h04, 32'h1);

        // R8 pin actions
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1) | pmode(1));
        wr(5'h08, 32'd2); pulse(3'b001, 1);
        check("R8 toggle up", {31'b0, out_pin}, 1);
        wr(5'h08, 32'd2); pulse(3'b001, 1);
        check("R8 toggle down", {31'b0, out_pin}, 0);
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1) | pmode(3));
        wr(5'h08, 32'd2); pulse(3'b001, 1);
        check("R8 set", {31'b0, out_pin}, 1);
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1) | pmode(2));
        wr(5'h08, 32'd2); pulse(3'b001, 1);
        check("R8 clear", {31'b0, out_pin}, 0);
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1) | pmode(3));
        wr(5'h08, 32'd2); pulse(3'b001, 1);
        check("R8 set again", {31'b0, out_pin}, 1);
        wr(5'h00, C_RUN | C_OVW | C_RLD | src(1) | pmode(0));
        check("R8 disconnected low", {31'b0, out_pin}, 0);

        // R9 / R10 restart versus resume
        wr(5'h00, 32'h0);
        wr(5'h08, 32'd500);
        chk_reg("R10 no overwrite", 5'h10, 32'd1);
        wr(5'h00, C_RUN | C_RST | src(1));
        chk_reg("R9 restart", 5'h10, 32'd500);
        pulse(3'b001, 2);
        chk_reg("R9 counting", 5'h10, 32'd498);
        wr(5'h00, src(1));
        pulse(3'b001, 3);
        chk_reg("R9 halted", 5'h10, 32'd498);
        wr(5'h00, C_RUN | src(1));
        chk_reg("R9 resume", 5'h10, 32'd498);
        pulse(3'b001, 1);
        chk_reg("R9 resumed step", 5'h10, 32'd497);

        // R11 software reset
        wr(5'h0C, 32'd7);
        wr(5'h04, 32'h0);
        wr(5'h00, C_SRST | C_IRQ | pmode(3));
        @(negedge clk);
        chk_reg("R11 ctrl", 5'h00, 32'h0);
        chk_reg("R11 load", 5'h08, 32'hFFFF_FFFF);
        chk_reg("R11 cmp",  5'h0C, 32'h0);
        chk_reg("R11 cnt",  5'h10, 32'hFFFF_FFFF);
        chk_reg("R11 stat", 5'h04, 32'h0);

        // R3 random divider / source runs
        for (int it = 0; it < 10; it++) begin
            logic [31:0] st;
            int p, s, ticks;
            logic [2:0] m;
            st = 32'h1000 + ($urandom % 32'h7000_0000);
            p = int'($urandom % 4);
            s = 1 + int'($urandom % 3);
            m = 3'(1 << (s - 1));
            ticks = 0;
            wr(5'h00, 32'h0);
            wr(5'h08, st);
            wr(5'h00, C_RUN | C_RST | src(s) | pdiv(p));
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if ($urandom % 2 == 1) begin
                    {t_lo, t_hi, t_per} = m;
                    ticks++;
                end else begin
                    {t_lo, t_hi, t_per} = 3'b000;
                end
            end
            @(negedge clk);
            {t_lo, t_hi, t_per} = 3'b000;
            chk_reg("R3 random", 5'h10, exp_count(st, ticks, p));
        end

        done = 1'b1;
        finish_run();
    end

endmodule